// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a small bank of token flags that two independent processor ports, called left and right, use to agree on who owns a shared resource. A port claims a flag by writing a zero to it and gives it back by writing a one. Each flag has one pending-request latch per side. A claim that arrives while the other side holds the flag is kept in that side's latch. When the owner releases the flag, the claim takes effect without any further action from the waiting side.

A read returns the flag as the reading port sees it, copied onto every data bit. All zeros means the reader owns the flag. All ones means it does not. The read value is captured once, at the start of a read access, and then held. A flag change made by the other port during a long read therefore cannot corrupt the value being read. Both ports sample on one clock and share an active-low synchronous reset.

Top module: `dual_port_token_bank`

## Requirements
- R1: The flag is picked by the low `$clog2(NUM_FLAGS)` address bits (bits 2:0 for eight flags). All higher address bits have no effect on which flag is written or read.
- R2: On a write, only data bit 0 is used (0 = request, 1 = release). Every other data bit is ignored.
- R3: When one port writes 0 to a free flag, that port then reads all zeros from it and the other port reads all ones.
- R4: A 0 written by the port that does not own the flag is stored in that port's request latch. That port keeps reading all ones, and the owner keeps ownership.
- R5: When the owner writes 1 while the other port has a pending 0, ownership passes straight to the other port. That port reads all zeros until it writes 1 itself.
- R6: When the owner writes 1 and no request is pending, the flag becomes free and both ports read all ones.
- R7: Read data is the flag bit as seen by the reading port, copied onto every data bit.
- R8: Read data is captured in the first cycle in which select and output enable are both active with write low. It then stays unchanged while that condition holds, even if the flag changes.
- R9: If both ports write 0 to the same free flag in the same cycle, the left port wins and the right request stays pending.
- R10: After reset every flag is free, every request latch holds 1, and both read-data outputs are all ones.
- R11: A port whose select is low changes no request latch and does not update its read-data output.
- R12: When a non-owning port writes 1, its pending request is withdrawn. A later release by the owner then leaves the flag free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left port semaphore select, active high |
| l_oe | input | 1 | Left port output enable, active high |
| l_wr | input | 1 | Left port direction, 1 = write, 0 = read |
| l_addr | input | ADDR_W | Left port address; only the low bits select a flag |
| l_wdata | input | DATA_W | Left port write data; only bit 0 is used |
| l_rdata | output | DATA_W | Left port held read data |
| r_sel | input | 1 | Right port semaphore select, active high |
| r_oe | input | 1 | Right port output enable, active high |
| r_wr | input | 1 | Right port direction, 1 = write, 0 = read |
| r_addr | input | ADDR_W | Right port address; only the low bits select a flag |
| r_wdata | input | DATA_W | Right port write data; only bit 0 is used |
| r_rdata | output | DATA_W | Right port held read data |

## Verification
The bench builds the block with its default values: eight flags, a 13-bit address and a 9-bit data bus. With these values every flag can be driven through the full claim, queue, hand-over and release cycle from both sides, and through the same-cycle tie. The ten unused upper address bits and eight unused data bits are filled with pseudo-random values. A long pseudo-random sequence of claims, releases and reads is checked against an arithmetic model in the bench. This sequence reaches interleavings of the two request latches that the directed cases do not reach.

// File: rtl/tokbank_pkg.sv
package tokbank_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Next owner from the current owner and the updated request latches
  // (latch value 0 = request pending). Left wins a same-cycle tie.
  function automatic owner_e next_owner(owner_e cur, logic lreq_n, logic rreq_n);
    owner_e nxt;
    nxt = cur;
    case (cur)
      OWN_LEFT:  if (lreq_n) nxt = rreq_n ? OWN_NONE : OWN_RIGHT;
      OWN_RIGHT: if (rreq_n) nxt = lreq_n ? OWN_NONE : OWN_LEFT;
      default: begin
        if (!lreq_n)      nxt = OWN_LEFT;
        else if (!rreq_n) nxt = OWN_RIGHT;
        else              nxt = OWN_NONE;
      end
    endcase
    return nxt;
  endfunction

  // Flag bit as seen from one side: 0 when that side owns the flag.
  function automatic logic seen_bit(owner_e cur, logic from_right);
    return from_right ? (cur != OWN_RIGHT) : (cur != OWN_LEFT);
  endfunction

endpackage

// File: rtl/tokbank_cell.sv
module tokbank_cell
  import tokbank_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   l_hit,
  input  logic   l_bit,
  input  logic   r_hit,
  input  logic   r_bit,
  output owner_e owner_q
);

  logic   req_l_q, req_r_q;
  logic   req_l_d, req_r_d;
  owner_e owner_d;

  always_comb begin
    req_l_d = l_hit ? l_bit : req_l_q;
    req_r_d = r_hit ? r_bit : req_r_q;
    owner_d = next_owner(owner_q, req_l_d, req_r_d);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_l_q <= 1'b1;
      req_r_q <= 1'b1;
      owner_q <= OWN_NONE;
    end else begin
      req_l_q <= req_l_d;
      req_r_q <= req_r_d;
      owner_q <= owner_d;
    end
  end

  AST_OWNER_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((owner_q == OWN_LEFT) |-> !req_l_q) and ((owner_q == OWN_RIGHT) |-> !req_r_q)); // R4
  AST_FREE_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_NONE) |-> (req_l_q && req_r_q)); // R6
  AST_TIE_LEFT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_NONE && l_hit && !l_bit && r_hit && !r_bit) |=> (owner_q == OWN_LEFT && !req_r_q)); // R9
  AST_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_LEFT && l_hit && l_bit && !req_r_q && !(r_hit && r_bit)) |=> (owner_q == OWN_RIGHT)); // R5

endmodule

// File: rtl/tokbank_reader.sv
module tokbank_reader #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              oe,
  input  logic              wr,
  input  logic              view_bit,
  output logic [DATA_W-1:0] rdata
);

  logic rd_act, rd_act_q, capture;

  assign rd_act  = sel && oe && !wr;
  assign capture = rd_act && !rd_act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_act_q <= 1'b0;
      rdata    <= '1;
    end else begin
      rd_act_q <= rd_act;
      if (capture) rdata <= {DATA_W{view_bit}};
    end
  end

  AST_HOLD_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && rd_act_q) |=> $stable(rdata)); // R8
  AST_RDATA_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata == '0) || (rdata == '1)); // R7
  AST_NO_CAPTURE_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(rdata)); // R11

endmodule

// File: rtl/dual_port_token_bank.sv
module dual_port_token_bank
  import tokbank_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic              l_oe,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_oe,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);

  localparam int IDX_W = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1;

  logic [IDX_W-1:0] l_idx, r_idx;
  logic             l_we, r_we;
  logic             l_view, r_view;
  owner_e           owner_w [NUM_FLAGS];

  // Upper address bits and upper data bits are deliberately unused (R1, R2).
  logic unused_port_bits;
  assign unused_port_bits = ^{l_addr[ADDR_W-1:IDX_W], r_addr[ADDR_W-1:IDX_W],
                              l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};

  assign l_idx = l_addr[IDX_W-1:0];
  assign r_idx = r_addr[IDX_W-1:0];
  assign l_we  = l_sel && l_wr;
  assign r_we  = r_sel && r_wr;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    tokbank_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .l_hit   (l_we && (l_idx == IDX_W'(g))),
      .l_bit   (l_wdata[0]),
      .r_hit   (r_we && (r_idx == IDX_W'(g))),
      .r_bit   (r_wdata[0]),
      .owner_q (owner_w[g])
    );
  end

  assign l_view = seen_bit(owner_w[l_idx], 1'b0);
  assign r_view = seen_bit(owner_w[r_idx], 1'b1);

  tokbank_reader #(.DATA_W(DATA_W)) u_rd_l (
    .clk(clk), .rst_n(rst_n), .sel(l_sel), .oe(l_oe), .wr(l_wr),
    .view_bit(l_view), .rdata(l_rdata)
  );

  tokbank_reader #(.DATA_W(DATA_W)) u_rd_r (
    .clk(clk), .rst_n(rst_n), .sel(r_sel), .oe(r_oe), .wr(r_wr),
    .view_bit(r_view), .rdata(r_rdata)
  );

endmodule

// File: tb/dual_port_token_bank_tb.sv
module dual_port_token_bank_tb_top;

  localparam int NF = 8;
  localparam int AW = 13;
  localparam int DW = 9;
  localparam logic [DW-1:0] ONES  = '1;
  localparam logic [DW-1:0] ZEROS = '0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sel = 0, l_oe = 0, l_wr = 0, r_sel = 0, r_oe = 0, r_wr = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  logic [31:0] rng = 32'h1234_5678;

  // bench model: owner 0 free, 1 left, 2 right; latch 0 = pending request
  int own [NF];
  bit lq [NF];
  bit rq [NF];

  always #5 clk = ~clk;

  dual_port_token_bank dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_oe(l_oe), .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_oe(r_oe), .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] step(logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expect_view(bit right, int i);
    int mine;
    mine = right ? 2 : 1;
    return (own[i] == mine) ? ZEROS : ONES;
  endfunction

  // model update after a cycle of writes
  task automatic model(bit lw, int li, bit lb, bit rw, int ri, bit rb);
    if (lw) lq[li] = lb;
    if (rw) rq[ri] = rb;
    for (int i = 0; i < NF; i++) begin
      if (own[i] == 1 && lq[i]) own[i] = rq[i] ? 0 : 2;
      else if (own[i] == 2 && rq[i]) own[i] = lq[i] ? 0 : 1;
      else if (own[i] == 0) own[i] = !lq[i] ? 1 : (!rq[i] ? 2 : 0);
    end
  endtask

  function automatic logic [AW-1:0] mk_addr(int i);
    rng = step(rng);
    return {rng[AW-1:3], 3'(i)};
  endfunction

  function automatic logic [DW-1:0] mk_data(bit b);
    rng = step(rng);
    return {rng[DW-1:1], b};
  endfunction

  task automatic dual_wr(bit lw, int li, bit lb, bit rw, int ri, bit rb);
    @(negedge clk);
    l_sel = lw; l_wr = lw; l_oe = 0; l_addr = mk_addr(li); l_wdata = mk_data(lb);
    r_sel = rw; r_wr = rw; r_oe = 0; r_addr = mk_addr(ri); r_wdata = mk_data(rb);
    @(negedge clk);
    l_sel = 0; l_wr = 0; r_sel = 0; r_wr = 0;
    model(lw, li, lb, rw, ri, rb);
  endtask

  task automatic wr(bit right, int i, bit b);
    if (right) dual_wr(0, 0, 1, 1, i, b);
    else       dual_wr(1, i, b, 0, 0, 1);
  endtask

  task automatic rd(bit right, int i, output logic [DW-1:0] d);
    @(negedge clk);
    if (right) begin r_sel = 1; r_oe = 1; r_wr = 0; r_addr = mk_addr(i); end
    else       begin l_sel = 1; l_oe = 1; l_wr = 0; l_addr = mk_addr(i); end
    @(negedge clk);
    d = right ? r_rdata : l_rdata;
    l_sel = 0; l_oe = 0; r_sel = 0; r_oe = 0;
  endtask

  task automatic rd_chk(string req, bit right, int i);
    logic [DW-1:0] d;
    rd(right, i, d);
    check(req, d, expect_view(right, i));
  endtask

  initial begin
    logic [DW-1:0] d;
    for (int i = 0; i < NF; i++) begin own[i] = 0; lq[i] = 1; rq[i] = 1; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 left rdata after reset", l_rdata, ONES);
    check("R10 right rdata after reset", r_rdata, ONES);
    for (int i = 0; i < NF; i++) begin
      rd_chk("R10 left flag free", 0, i);
      rd_chk("R10 right flag free", 1, i);
    end

    // claim / queue / hand-over / release on every flag from both sides
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < NF; i++) begin
        bit a, b;
        a = bit'(s); b = !a;
        wr(a, i, 0);
        rd_chk("R3 claimer reads zeros", a, i);
        rd_chk("R3 other reads ones", b, i);
        wr(b, i, 0);
        rd_chk("R4 queued side reads ones", b, i);
        rd_chk("R4 owner keeps flag", a, i);
        wr(a, i, 1);
        rd_chk("R5 waiting side now owns", b, i);
        rd_chk("R5 old owner reads ones", a, i);
        wr(b, i, 1);
        rd_chk("R6 left sees free", 0, i);
        rd_chk("R6 right sees free", 1, i);
      end
    end

    // same-cycle tie on each flag
    for (int i = 0; i < NF; i++) begin
      dual_wr(1, i, 0, 1, i, 0);
      check("R9 model left owner", 9'(own[i]), 9'd1);
      rd_chk("R9 left wins tie", 0, i);
      rd_chk("R9 right loses tie", 1, i);
      wr(0, i, 1);
      rd_chk("R9 right pending served", 1, i);
      wr(1, i, 1);
    end

    // withdrawal of a pending request
    wr(0, 3, 0); wr(1, 3, 0); wr(1, 3, 1); wr(0, 3, 1);
    rd_chk("R12 flag free after withdraw (left)", 0, 3);
    rd_chk("R12 flag free after withdraw (right)", 1, 3);

    // read hold while select and output enable stay active
    wr(1, 5, 0); wr(0, 5, 0);
    @(negedge clk);
    l_sel = 1; l_oe = 1; l_wr = 0; l_addr = mk_addr(5);
    @(negedge clk);
    check("R8 initial held read", l_rdata, ONES);
    r_sel = 1; r_wr = 1; r_addr = mk_addr(5); r_wdata = mk_data(1);
    @(negedge clk);
    r_sel = 0; r_wr = 0;
    model(0, 0, 1, 1, 5, 1);
    repeat (2) @(negedge clk);
    check("R8 held read unchanged after flag moved", l_rdata, ONES);
    l_sel = 0; l_oe = 0;
    rd_chk("R5 left owns after hand-over", 0, 5);
    check("R7 read all zeros when owned", l_rdata, ZEROS);

    // unselected port: no capture, no latch change
    @(negedge clk);
    l_sel = 0; l_oe = 1; l_wr = 0; l_addr = mk_addr(6);
    repeat (2) @(negedge clk);
    check("R11 no capture without select", l_rdata, ZEROS);
    l_wr = 1; l_wdata = mk_data(0);
    repeat (2) @(negedge clk);
    l_wr = 0; l_oe = 0;
    rd_chk("R11 unselected write ignored (right view)", 1, 6);
    rd_chk("R11 unselected write ignored (left view)", 0, 6);
    wr(0, 5, 1);

    // pseudo-random sweep, noisy upper address/data bits
    for (int n = 0; n < 3000; n++) begin
      int k, i, j;
      rng = step(rng);
      k = int'(rng[2:0]);
      i = int'(rng[6:4]);
      j = int'(rng[10:8]);
      case (k)
        0, 1: wr(rng[12], i, rng[13]);
        2:    dual_wr(1, i, rng[13], 1, j, rng[14]);
        default: rd_chk("R1/R2/R7 sweep read", rng[12], i);
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule